// File: doc/BRIEF.md
# Processor Bus Target Wait-State Adapter

This block sits on the target side of a synchronous processor system bus whose transfers are framed by two active-low one-clock pulses: a start strobe from the master and an acknowledge from the target. When the start strobe is seen while the adapter is idle, it registers the address, direction, transfer size and a four-bit address-type tag. It holds these stable toward a simple internal register port, counts a programmable number of wait states, and then completes the transfer with a single-clock acknowledge. In that same acknowledge cycle it either drives read data onto the bus or hands the write data to the internal port with byte enables.

The bus data path is 32 bits wide with big-endian byte numbering. Byte, halfword and word accesses are supported. The wait-state count is taken from an input on the start cycle, so a system can select the timing for each region it decodes. A start strobe that arrives while a transfer is still open is ignored and reported on a protocol-error output.

The controller has three states. `ST_IDLE` moves to `ST_WAIT` when a start is accepted with a nonzero wait count, and moves to `ST_ACK` when a start is accepted with a zero count. `ST_WAIT` moves to `ST_ACK` when the wait counter reaches its last cycle. `ST_ACK` always returns to `ST_IDLE`. A synchronous reset forces `ST_IDLE` from any state.

Top module: `pbus_wait_adapter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters idle. After that edge `ack_n` is 1, `data_oe` is 0, `rdata_out` is 0, `proto_err` is 0, and `int_rd_en` and `int_wr_en` are 0. This also applies when reset arrives in the middle of a transfer.
- R2: A low `start_n` sampled while the block is idle accepts a transfer. `int_addr`, `int_read` and `int_size` then show the values that `addr`, `rd_wr_n` and `xfer_size` had on the start cycle. They stay at those values until the acknowledge cycle, even if the bus lines change.
- R3: `wait_cfg` (0 to 15) is sampled on the start cycle. For a value N, `ack_n` is low in exactly the (N+1)-th clock after the start cycle, so a transfer lasts N+2 clocks. With N = 0, acknowledge comes in the clock immediately after the start.
- R4: `ack_n` is never low for two clocks in a row.
- R5: In the acknowledge cycle of a read, `data_oe` is 1 and `rdata_out` equals `int_rdata`. In every other cycle, `data_oe` is 0 and `rdata_out` is 0.
- R6: In the acknowledge cycle of a write, and only then, `int_wr_en` is 1 and `int_wdata` equals `wdata_in` of that cycle.
- R7: `int_be` bit i enables data bits [8i+7:8i]. Address offset 0 is the most significant byte. The `xfer_size` codes are 01 for byte, 10 for halfword, and 00 or 11 for word. A byte at offset k gives `int_be` = 1 << (3-k). A halfword gives 1100 when addr[1] is 0 and 0011 when addr[1] is 1. A word gives 1111.
- R8: A low `start_n` while a transfer is open is ignored. The captured qualifiers and the acknowledge timing of the open transfer do not change. `proto_err` is 1 in the clock after that start.
- R9: `int_kind` shows the `addr_type` value from the start cycle. The address type has no effect on acknowledge timing.
- R10: A start in the first clock after an acknowledge is accepted as a new transfer.
- R11: `int_rd_en` is 1 only in the acknowledge cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Transfer-start strobe, active low |
| addr | input | 32 | Bus address |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| xfer_size | input | 2 | Access size code |
| addr_type | input | 4 | Address-type tag |
| wait_cfg | input | 4 | Wait states for this transfer |
| wdata_in | input | 32 | Write data from the master |
| rdata_out | output | 32 | Read data to the master |
| data_oe | output | 1 | Output enable for the read data |
| ack_n | output | 1 | Transfer acknowledge, active low |
| proto_err | output | 1 | Start seen during an open transfer |
| int_addr | output | 32 | Captured address |
| int_kind | output | 4 | Captured address type |
| int_size | output | 2 | Captured size code |
| int_read | output | 1 | Captured direction |
| int_be | output | 4 | Byte-lane enables |
| int_rd_en | output | 1 | Internal read strobe |
| int_wr_en | output | 1 | Internal write strobe |
| int_wdata | output | 32 | Write data to the internal port |
| int_rdata | input | 32 | Read data from the internal port |

## Verification
The vector table mixes byte, halfword and word writes at every lane offset, including the reserved size code. Each write is read back as a full word. A misplaced byte enable therefore shows up as wrong data, not only as a wrong `int_be` value. Wait counts of 0, 1, intermediate values and 15 separate an off-by-one in the counter from a stuck acknowledge. Bus lines are scrambled right after each start, which separates true capture from pass-through. Directed cases cover a second start inside an open transfer, reset in the middle of a wait, and back-to-back transfers.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

    localparam int LANES  = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } pbw_state_e;

    localparam logic [1:0] SZ_WORD = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_HALF = 2'b10;

    // Big-endian lanes: offset 0 is the most significant byte (bit LANES-1).
    function automatic logic [LANES-1:0] lane_mask(input logic [1:0] size,
                                                   input logic [1:0] off);
        logic [LANES-1:0] m;
        unique case (size)
            SZ_BYTE: m = 4'b1000 >> off;
            SZ_HALF: m = off[1] ? 4'b0011 : 4'b1100;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pbw_qual_latch.sv
module pbw_qual_latch
    import pbw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KIND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic [1:0]        size,
    input  logic [KIND_W-1:0] kind,
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_rd,
    output logic [1:0]        q_size,
    output logic [KIND_W-1:0] q_kind,
    output logic [LANES-1:0]  q_be
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr <= '0;
            q_rd   <= 1'b0;
            q_size <= SZ_WORD;
            q_kind <= '0;
        end else if (capture) begin
            q_addr <= addr;
            q_rd   <= rd;
            q_size <= size;
            q_kind <= kind;
        end
    end

    always_comb begin
        q_be = lane_mask(q_size, q_addr[1:0]);
    end

    // R7
    be_byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_size == SZ_BYTE) |-> ($countones(q_be) == 1));

    // R7
    be_half_two_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_size == SZ_HALF) |-> ($countones(q_be) == 2));

endmodule

// File: rtl/pbw_wait_timer.sv
module pbw_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

    // R3
    timer_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q != '0));

endmodule

// File: rtl/pbw_fsm.sv
module pbw_fsm
    import pbw_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_n,
    input  logic [CNT_W-1:0] wait_cfg,
    input  logic             timer_last,
    output pbw_state_e       state,
    output logic             accept,
    output logic             in_wait,
    output logic             in_ack,
    output logic             proto_err
);

    pbw_state_e state_q, state_d;
    logic       clash;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!start_n) state_d = (wait_cfg == '0) ? ST_ACK : ST_WAIT;
            ST_WAIT: if (timer_last) state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = (state_q == ST_IDLE) && !start_n;
        clash   = (state_q != ST_IDLE) && !start_n;
        in_wait = (state_q == ST_WAIT);
        in_ack  = (state_q == ST_ACK);
        state   = state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_err <= 1'b0;
        end else begin
            proto_err <= clash;
        end
    end

    // R3
    zero_wait_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_n && wait_cfg == '0) |=> (state_q == ST_ACK));

    // R8
    proto_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !start_n) |=> proto_err);

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/pbus_wait_adapter.sv
module pbus_wait_adapter
    import pbw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KIND_W = 4,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_wr_n,
    input  logic [1:0]        xfer_size,
    input  logic [KIND_W-1:0] addr_type,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [DATA_W-1:0] rdata_out,
    output logic              data_oe,
    output logic              ack_n,
    output logic              proto_err,
    output logic [ADDR_W-1:0] int_addr,
    output logic [KIND_W-1:0] int_kind,
    output logic [1:0]        int_size,
    output logic              int_read,
    output logic [LANES-1:0]  int_be,
    output logic              int_rd_en,
    output logic              int_wr_en,
    output logic [DATA_W-1:0] int_wdata,
    input  logic [DATA_W-1:0] int_rdata
);

    pbw_state_e state;
    logic       accept, in_wait, in_ack, timer_last;

    pbw_fsm #(.CNT_W(WAIT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_n    (start_n),
        .wait_cfg   (wait_cfg),
        .timer_last (timer_last),
        .state      (state),
        .accept     (accept),
        .in_wait    (in_wait),
        .in_ack     (in_ack),
        .proto_err  (proto_err)
    );

    pbw_wait_timer #(.CNT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_cfg),
        .run      (in_wait),
        .last     (timer_last)
    );

    pbw_qual_latch #(.ADDR_W(ADDR_W), .KIND_W(KIND_W)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .addr    (addr),
        .rd      (rd_wr_n),
        .size    (xfer_size),
        .kind    (addr_type),
        .q_addr  (int_addr),
        .q_rd    (int_read),
        .q_size  (int_size),
        .q_kind  (int_kind),
        .q_be    (int_be)
    );

    always_comb begin
        ack_n     = !in_ack;
        int_rd_en = in_ack && int_read;
        int_wr_en = in_ack && !int_read;
        int_wdata = wdata_in;
        data_oe   = int_rd_en;
        rdata_out = int_rd_en ? int_rdata : '0;
    end

    // R4
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> ack_n);

    // R5
    oe_read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!ack_n && int_read));

    // R6
    wr_en_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr_en |-> (!ack_n && !data_oe && int_be != '0));

    // R2
    qual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |=> $stable(int_addr));

endmodule

// File: tb/pbus_wait_adapter_tb.sv
module pbus_wait_adapter_tb;

    typedef struct packed {
        logic        rd;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [3:0]  kind;
        logic [3:0]  ws;
        logic [31:0] wd;
        logic [3:0]  be;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 32'h0000_0010, 4'h1, 4'd0,  32'h1122_3344, 4'b1111},
        '{1'b0, 2'b01, 32'h0000_0015, 4'h2, 4'd2,  32'hAABB_CCDD, 4'b0100},
        '{1'b0, 2'b10, 32'h0000_001A, 4'h3, 4'd15, 32'h1234_5678, 4'b0011},
        '{1'b0, 2'b10, 32'h0000_000C, 4'h4, 4'd1,  32'hCAFE_BABE, 4'b1100},
        '{1'b0, 2'b01, 32'h0000_0013, 4'h9, 4'd0,  32'h0000_00EE, 4'b0001},
        '{1'b1, 2'b00, 32'h0000_0010, 4'h5, 4'd0,  32'h0000_0000, 4'b1111},
        '{1'b1, 2'b01, 32'h0000_0014, 4'hA, 4'd7,  32'h0000_0000, 4'b1000},
        '{1'b1, 2'b10, 32'h0000_0018, 4'hF, 4'd15, 32'h0000_0000, 4'b1100},
        '{1'b0, 2'b11, 32'h0000_000C, 4'h6, 4'd3,  32'h0BAD_F00D, 4'b1111},
        '{1'b1, 2'b00, 32'h0000_000C, 4'h0, 4'd1,  32'h0000_0000, 4'b1111},
        '{1'b0, 2'b01, 32'h0000_0018, 4'h7, 4'd4,  32'h7700_0000, 4'b1000},
        '{1'b1, 2'b00, 32'h0000_0018, 4'hC, 4'd0,  32'h0000_0000, 4'b1111}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_n = 1'b1;
    logic [31:0] addr = '0;
    logic        rd_wr_n = 1'b1;
    logic [1:0]  xfer_size = '0;
    logic [3:0]  addr_type = '0;
    logic [3:0]  wait_cfg = '0;
    logic [31:0] wdata_in = '0;
    logic [31:0] rdata_out, int_addr, int_wdata, int_rdata;
    logic        data_oe, ack_n, proto_err, int_read, int_rd_en, int_wr_en;
    logic [3:0]  int_kind, int_be;
    logic [1:0]  int_size;

    logic [31:0] pmem [4];
    logic [31:0] exp_mem [4];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pbus_wait_adapter u_dut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .addr(addr),
        .rd_wr_n(rd_wr_n), .xfer_size(xfer_size), .addr_type(addr_type),
        .wait_cfg(wait_cfg), .wdata_in(wdata_in), .rdata_out(rdata_out),
        .data_oe(data_oe), .ack_n(ack_n), .proto_err(proto_err),
        .int_addr(int_addr), .int_kind(int_kind), .int_size(int_size),
        .int_read(int_read), .int_be(int_be), .int_rd_en(int_rd_en),
        .int_wr_en(int_wr_en), .int_wdata(int_wdata), .int_rdata(int_rdata)
    );

    // Small register array standing in for the internal peripheral
    assign int_rdata = pmem[int_addr[3:2]];
    always_ff @(posedge clk) begin
        if (int_wr_en) begin
            for (int i = 0; i < 4; i++)
                if (int_be[i]) pmem[int_addr[3:2]][8*i +: 8] <= int_wdata[8*i +: 8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
        return r;
    endfunction

    // Called at a negedge; leaves at the negedge after the acknowledge cycle.
    task automatic run_vec(input vec_t v);
        int seen = 0;
        start_n = 1'b0; addr = v.addr; rd_wr_n = v.rd; xfer_size = v.sz;
        addr_type = v.kind; wait_cfg = v.ws; wdata_in = v.wd;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start_n = 1'b1; addr = 32'hDEAD_BEE0; rd_wr_n = ~v.rd;
                xfer_size = ~v.sz; addr_type = ~v.kind; wait_cfg = 4'd9;
            end
            if (k <= v.ws) chk("R5 oe low while waiting", {31'd0, data_oe}, 32'd0);
            if (!ack_n) begin seen = k; break; end
        end
        chk("R3 ack clock after start", seen, v.ws + 1);
        chk("R2 captured addr", int_addr, v.addr);
        chk("R2 captured dir", {31'd0, int_read}, {31'd0, v.rd});
        chk("R9 captured addr type", {28'd0, int_kind}, {28'd0, v.kind});
        chk("R7 byte enables", {28'd0, int_be}, {28'd0, v.be});
        chk("R11 read strobe", {31'd0, int_rd_en}, {31'd0, v.rd});
        chk("R5 output enable", {31'd0, data_oe}, {31'd0, v.rd});
        if (v.rd) begin
            chk("R5 read data", rdata_out, exp_mem[v.addr[3:2]]);
        end else begin
            chk("R6 write strobe", {31'd0, int_wr_en}, 32'd1);
            chk("R6 write data", int_wdata, v.wd);
            chk("R5 bus idle on write", rdata_out, 32'd0);
            exp_mem[v.addr[3:2]] = merge(exp_mem[v.addr[3:2]], v.wd, v.be);
        end
        @(negedge clk);
        chk("R4 ack released", {31'd0, ack_n}, 32'd1);
        chk("R5 oe released", {31'd0, data_oe}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin pmem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ack_n in reset", {31'd0, ack_n}, 32'd1);
        chk("R1 oe in reset", {31'd0, data_oe}, 32'd0);
        chk("R1 proto_err in reset", {31'd0, proto_err}, 32'd0);
        chk("R1 strobes in reset", {30'd0, int_rd_en, int_wr_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table, back-to-back (R10)
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R8: second start inside an open transfer
        start_n = 1'b0; addr = 32'h10; rd_wr_n = 1'b0; xfer_size = 2'b00;
        addr_type = 4'h3; wait_cfg = 4'd3; wdata_in = 32'h5555_AAAA;
        @(negedge clk);
        addr = 32'h1C; rd_wr_n = 1'b1; wait_cfg = 4'd0;
        @(negedge clk);
        start_n = 1'b1;
        chk("R8 proto_err after busy start", {31'd0, proto_err}, 32'd1);
        chk("R8 no early ack", {31'd0, ack_n}, 32'd1);
        @(negedge clk);
        chk("R8 proto_err one clock", {31'd0, proto_err}, 32'd0);
        @(negedge clk);
        chk("R8 ack timing kept", {31'd0, ack_n}, 32'd0);
        chk("R8 address kept", int_addr, 32'h10);
        chk("R8 direction kept", {31'd0, int_wr_en}, 32'd1);
        exp_mem[0] = 32'h5555_AAAA;
        @(negedge clk);

        // R1: reset during a wait
        start_n = 1'b0; addr = 32'h14; rd_wr_n = 1'b1; wait_cfg = 4'd6;
        @(negedge clk);
        start_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ack_n after mid reset", {31'd0, ack_n}, 32'd1);
        chk("R1 oe after mid reset", {31'd0, data_oe}, 32'd0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R1 no stale ack", {31'd0, ack_n}, 32'd1);
        end
        // R10: block usable again after reset
        run_vec('{1'b1, 2'b00, 32'h10, 4'h2, 4'd2, 32'h0, 4'b1111});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule